// File: doc/BRIEF.md
# DC-Balanced Video/Control Word Framer

This block turns a stream of parallel display data into a single serial bit stream. On every word strobe it samples an 18-bit pixel value, a 9-bit control value and a data-enable qualifier. It forms one 20-bit word per strobe and shifts that word out one bit per serial clock, least significant bit first. The serial clock runs at twenty times the word rate. The environment supplies that clock and raises `word_en` for one serial clock in every twenty. The block has no clock multiplier of its own.

Each word is one of three kinds. A video word is sent while the qualifier is high. A control word is sent during blanking, and each of the five low control bits is repeated three times so that a receiver can recover it by majority vote. A fixed transition word fills the two slots on either side of every change of the qualifier. The control inputs are ignored in those slots. The block tracks the running disparity of the whole stream. When a payload would push that disparity further from zero, the block inverts the payload and flags the inversion in bit 0 of the word.

The block holds a look-ahead pipeline of two word slots. The transition words before a rising qualifier can therefore replace the last blanking slots without dropping any video data. Inputs reach the serial line three word periods after they are sampled.

Top module: `dcb_framer`

## Requirements
- R1: While reset is asserted, and after reset until the first word strobe, `ser_out` is 0.
- R2: Each `word_en` pulse loads one 20-bit word. Bit 0 appears on `ser_out` in the serial clock after the strobe edge, followed by bits 1 to 19 on the next nineteen serial clocks. Strobes are spaced exactly 20 serial clocks apart.
- R3: A video word has the inversion flag in bit 0 and a constant 1 in bit 1. Bits 2 to 19 carry pixel bits 0 to 17, and each of these bits is complemented when the flag is 1.
- R4: A control word has the inversion flag in bit 0. Bits 1 to 15 carry control bits 0 to 4, each repeated three times in that order: bits 1 to 3 carry control bit 0, and so on. Bits 16 to 19 carry control bits 5 to 8. When the flag is 1, bits 1 to 19 are complemented.
- R5: A transition word has bits 0 to 9 set to 1 and bits 10 to 19 set to 0 (value 20'h003FF). It does not change the running disparity.
- R6: The two slots just before a slot sampled with the qualifier high carry transition words whenever the qualifier was low in those slots. The control inputs sampled in those slots have no effect.
- R7: The two slots just after the last slot sampled with the qualifier high carry transition words whenever the qualifier is low in those slots.
- R8: In video slots the control inputs have no effect. In control slots the pixel inputs have no effect.
- R9: Running disparity is the count of 1s minus the count of 0s in all words sent since reset, starting from 0. A payload is inverted exactly when its own disparity is nonzero and has the same sign as the running disparity. The running disparity therefore never moves further from zero while it is nonzero, and it stays within plus or minus 20.
- R10: Inputs sampled at strobe n form the word that is loaded at strobe n+3.
- R11: A blanking gap shorter than five slots between two video slots is sent entirely as transition words. A gap of exactly five slots carries one control word in its middle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial bit clock, twenty times the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| word_en | input | 1 | One-cycle word strobe that samples the inputs and loads the shifter |
| pix_valid | input | 1 | Data-enable qualifier: 1 selects pixel data, 0 selects control data |
| pix_data | input | 18 | Pixel bits |
| ctl_data | input | 9 | Control bits |
| ser_out | output | 1 | Serial data, LSB of each word first |

## Verification
The hardest behaviour to reach is the look-ahead guard. A transition word must appear before the qualifier rises, so the right output depends on inputs sampled two strobes later. Short blanking gaps of one, three and five slots, and a single-slot video burst, bring both guards into the same slots. During these gaps the control and pixel inputs change in every slot, so that any leak would show up in the received words. The inversion rule is reached by runs of all-ones and all-zeros pixels and by control values of extreme weight, which drive the running disparity to both signs. The bench then compares every reassembled word against its own disparity model.

// File: rtl/dcb_framer_pkg.sv
package dcb_framer_pkg;
  typedef enum logic [1:0] {
    KIND_CTRL  = 2'd0,
    KIND_VIDEO = 2'd1,
    KIND_TRANS = 2'd2
  } word_kind_e;
endpackage

// File: rtl/dcb_slot_pipe.sv
// Word-rate look-ahead pipeline: holds LOOK newer slots ahead of the slot
// being framed, plus the qualifier history of LOOK already framed slots.
module dcb_slot_pipe #(
  parameter int PIX_W = 18,
  parameter int CTL_W = 9,
  parameter int LOOK  = 2
) (
  input  logic             clk_ser,
  input  logic             rst_n,
  input  logic             word_en,
  input  logic             de_in,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [CTL_W-1:0] ctl_in,
  output logic             cur_de,
  output logic [PIX_W-1:0] cur_pix,
  output logic [CTL_W-1:0] cur_ctl,
  output logic             ahead_any,
  output logic             behind_any
);
  localparam int DEPTH = LOOK + 1;

  logic [DEPTH-1:0] de_q;
  logic [LOOK-1:0]  de_hist;
  logic [PIX_W-1:0] pix_q [DEPTH];
  logic [CTL_W-1:0] ctl_q [DEPTH];

  always_ff @(posedge clk_ser) begin
    if (!rst_n) begin
      de_q    <= '0;
      de_hist <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pix_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else if (word_en) begin
      de_q[0]  <= de_in;
      pix_q[0] <= pix_in;
      ctl_q[0] <= ctl_in;
      for (int i = 1; i < DEPTH; i++) begin
        de_q[i]  <= de_q[i-1];
        pix_q[i] <= pix_q[i-1];
        ctl_q[i] <= ctl_q[i-1];
      end
      de_hist[0] <= de_q[DEPTH-1];
      for (int i = 1; i < LOOK; i++) de_hist[i] <= de_hist[i-1];
    end
  end

  assign cur_de     = de_q[DEPTH-1];
  assign cur_pix    = pix_q[DEPTH-1];
  assign cur_ctl    = ctl_q[DEPTH-1];
  assign ahead_any  = |de_q[DEPTH-2:0];
  assign behind_any = |de_hist;
endmodule

// File: rtl/dcb_phase_sel.sv
module dcb_phase_sel
  import dcb_framer_pkg::*;
(
  input  logic       cur_de,
  input  logic       ahead_any,
  input  logic       behind_any,
  output word_kind_e kind
);
  always_comb begin
    if (cur_de)                       kind = KIND_VIDEO;
    else if (ahead_any || behind_any) kind = KIND_TRANS;
    else                              kind = KIND_CTRL;
  end
endmodule

// File: rtl/dcb_balance_enc.sv
// Builds the 20-bit word for the current slot and keeps running disparity.
module dcb_balance_enc
  import dcb_framer_pkg::*;
#(
  parameter int PIX_W      = 18,
  parameter int CTL_W      = 9,
  parameter int CTL_REP    = 3,
  parameter int CTL_TRIPLE = 5,
  parameter int WORD_W     = 20,
  parameter int RD_W       = 8
) (
  input  logic                   clk_ser,
  input  logic                   rst_n,
  input  logic                   word_en,
  input  word_kind_e             kind,
  input  logic [PIX_W-1:0]       pix,
  input  logic [CTL_W-1:0]       ctl,
  output logic [WORD_W-1:0]      word,
  output logic signed [RD_W-1:0] rd,
  output logic signed [RD_W-1:0] rd_next
);
  localparam int VID_OVH = WORD_W - PIX_W;
  localparam int CTL_OVH = 1;
  localparam logic [WORD_W-1:0] TRANS_WORD =
    {{(WORD_W - WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}};
  localparam logic [WORD_W-1:0] VID_MASK = {{PIX_W{1'b1}}, {VID_OVH{1'b0}}};
  localparam logic [WORD_W-1:0] CTL_MASK = {{(WORD_W-CTL_OVH){1'b1}}, {CTL_OVH{1'b0}}};

  function automatic int ones_in(input logic [WORD_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(v[i]);
    return n;
  endfunction

  // disparity of the bits of v selected by m
  function automatic int disp_of(input logic [WORD_W-1:0] v, input logic [WORD_W-1:0] m);
    return 2 * ones_in(v & m) - ones_in(m);
  endfunction

  function automatic logic [WORD_W-1:0] ctl_spread(input logic [CTL_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < CTL_TRIPLE; i++)
      for (int r = 0; r < CTL_REP; r++) w[CTL_OVH + i*CTL_REP + r] = c[i];
    for (int i = CTL_TRIPLE; i < CTL_W; i++)
      w[CTL_OVH + CTL_TRIPLE*CTL_REP + (i - CTL_TRIPLE)] = c[i];
    return w;
  endfunction

  function automatic logic flip_needed(input int run, input int pd);
    return (run > 0 && pd > 0) || (run < 0 && pd < 0);
  endfunction

  logic [WORD_W-1:0] raw, mask;
  logic              inv;
  int                run_i, word_d;

  always_comb begin
    run_i = int'(rd);
    raw   = '0;
    mask  = '0;
    inv   = 1'b0;
    word  = TRANS_WORD;
    if (kind != KIND_TRANS) begin
      if (kind == KIND_VIDEO) begin
        raw  = {pix, {VID_OVH{1'b0}}};
        mask = VID_MASK;
      end else begin
        raw  = ctl_spread(ctl);
        mask = CTL_MASK;
      end
      inv  = flip_needed(run_i, disp_of(raw, mask));
      word = raw ^ (inv ? mask : '0);
      word[0] = inv;
      if (kind == KIND_VIDEO) word[1] = 1'b1;
    end
    word_d  = 2 * ones_in(word) - WORD_W;
    rd_next = RD_W'(run_i + word_d);
  end

  always_ff @(posedge clk_ser) begin
    if (!rst_n)       rd <= '0;
    else if (word_en) rd <= rd_next;
  end
endmodule

// File: rtl/dcb_shifter.sv
module dcb_shifter #(
  parameter int WORD_W = 20
) (
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic              word_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_out
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk_ser) begin
    if (!rst_n)       shreg <= '0;
    else if (word_en) shreg <= word_in;
    else              shreg <= {1'b0, shreg[WORD_W-1:1]};
  end

  assign ser_out = shreg[0];
endmodule

// File: rtl/dcb_framer.sv
module dcb_framer
  import dcb_framer_pkg::*;
#(
  parameter int PIX_W      = 18,
  parameter int CTL_W      = 9,
  parameter int CTL_REP    = 3,
  parameter int CTL_TRIPLE = 5,
  parameter int WORD_W     = 20,
  parameter int LOOK       = 2
) (
  input  logic             clk_ser,
  input  logic             rst_n,
  input  logic             word_en,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [CTL_W-1:0] ctl_data,
  output logic             ser_out
);
  localparam int RD_W = $clog2(WORD_W) + 3;

  logic                   cur_de, ahead_any, behind_any;
  logic [PIX_W-1:0]       cur_pix;
  logic [CTL_W-1:0]       cur_ctl;
  word_kind_e             kind;
  logic [WORD_W-1:0]      load_word;
  logic signed [RD_W-1:0] rd, rd_next;

  dcb_slot_pipe #(.PIX_W(PIX_W), .CTL_W(CTL_W), .LOOK(LOOK)) u_pipe (
    .clk_ser(clk_ser), .rst_n(rst_n), .word_en(word_en),
    .de_in(pix_valid), .pix_in(pix_data), .ctl_in(ctl_data),
    .cur_de(cur_de), .cur_pix(cur_pix), .cur_ctl(cur_ctl),
    .ahead_any(ahead_any), .behind_any(behind_any)
  );

  dcb_phase_sel u_sel (
    .cur_de(cur_de), .ahead_any(ahead_any), .behind_any(behind_any), .kind(kind)
  );

  dcb_balance_enc #(
    .PIX_W(PIX_W), .CTL_W(CTL_W), .CTL_REP(CTL_REP), .CTL_TRIPLE(CTL_TRIPLE),
    .WORD_W(WORD_W), .RD_W(RD_W)
  ) u_enc (
    .clk_ser(clk_ser), .rst_n(rst_n), .word_en(word_en), .kind(kind),
    .pix(cur_pix), .ctl(cur_ctl), .word(load_word), .rd(rd), .rd_next(rd_next)
  );

  dcb_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_ser(clk_ser), .rst_n(rst_n), .word_en(word_en),
    .word_in(load_word), .ser_out(ser_out)
  );
endmodule

// File: rtl/dcb_framer_chk.sv
module dcb_framer_chk
  import dcb_framer_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int RD_W   = 8
) (
  input logic                   clk_ser,
  input logic                   rst_n,
  input logic                   word_en,
  input logic                   cur_de,
  input logic                   ahead_any,
  input word_kind_e             kind,
  input logic [WORD_W-1:0]      load_word,
  input logic signed [RD_W-1:0] rd,
  input logic signed [RD_W-1:0] rd_next,
  input logic                   ser_out
);
  localparam int CW = $clog2(WORD_W) + 1;

  logic          seen_load, prev_video;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk_ser) begin
    if (!rst_n) begin
      seen_load  <= 1'b0;
      prev_video <= 1'b0;
      gap_cnt    <= '0;
    end else if (word_en) begin
      seen_load  <= 1'b1;
      prev_video <= cur_de;
      gap_cnt    <= '0;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !seen_load |-> !ser_out);
  // R2
  word_spacing_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && seen_load |-> gap_cnt == CW'(WORD_W - 1));
  // R3
  video_slot_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && cur_de |-> kind == KIND_VIDEO && load_word[1]);
  // R5
  trans_first_bit_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && kind == KIND_TRANS |=> ser_out);
  // R6
  lead_guard_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && !cur_de && ahead_any |-> kind == KIND_TRANS);
  // R7
  trail_guard_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && prev_video && !cur_de |-> kind == KIND_TRANS);
  // R9
  shrink_pos_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && rd > 0 |-> rd_next <= rd);
  // R9
  shrink_neg_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    word_en && rd < 0 |-> rd_next >= rd);
  // R9
  rd_bound_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
    rd <= RD_W'(WORD_W) && rd >= -RD_W'(WORD_W));
endmodule

bind dcb_framer dcb_framer_chk #(.WORD_W(WORD_W), .RD_W(RD_W)) u_chk (
  .clk_ser(clk_ser), .rst_n(rst_n), .word_en(word_en), .cur_de(cur_de),
  .ahead_any(ahead_any), .kind(kind), .load_word(load_word), .rd(rd),
  .rd_next(rd_next), .ser_out(ser_out)
);

// File: tb/test_dcb_framer.sv
module test_dcb_framer;
  localparam int WORD_W = 20;
  localparam int PIX_W  = 18;
  localparam int CTL_W  = 9;
  localparam int LOOK   = 2;

  logic             clk_ser = 1'b0;
  logic             rst_n = 1'b0;
  logic             word_en = 1'b0;
  logic             pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic [CTL_W-1:0] ctl_data = '0;
  logic             ser_out;

  always #10 clk_ser = ~clk_ser;

  dcb_framer i_dcb_framer (
    .clk_ser(clk_ser), .rst_n(rst_n), .word_en(word_en), .pix_valid(pix_valid),
    .pix_data(pix_data), .ctl_data(ctl_data), .ser_out(ser_out)
  );

  int n_vec = 0;
  int n_bad = 0;

  bit               s_de[$];
  logic [PIX_W-1:0] s_pix[$];
  logic [CTL_W-1:0] s_ctl[$];
  logic [WORD_W-1:0] exp_q[$];
  string             tag_q[$];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver side: queue one word slot of stimulus
  task automatic add_slot(input bit de, input logic [PIX_W-1:0] p, input logic [CTL_W-1:0] c);
    s_de.push_back(de);
    s_pix.push_back(p);
    s_ctl.push_back(c);
  endtask

  task automatic add_video(input int n, input int seed);
    for (int i = 0; i < n; i++)
      add_slot(1'b1, PIX_W'((seed + i) * 32'h0001_3C5B ^ 32'h0002_A5A5), CTL_W'(i * 37 + 5));
  endtask

  task automatic add_ctrl(input int n, input int seed);
    for (int i = 0; i < n; i++)
      add_slot(1'b0, PIX_W'(i * 32'h0000_7711 + seed), CTL_W'((seed + i) * 61 ^ 9'h0A5));
  endtask

  function automatic int weight(input logic [WORD_W-1:0] w, input int lo);
    int n;
    n = 0;
    for (int b = lo; b < WORD_W; b++) if (w[b]) n++;
    return n;
  endfunction

  // reference model: one expected word per slot, including the reset slots
  task automatic build_expected();
    int n, run;
    bit de_a[];
    logic [PIX_W-1:0] px_a[];
    logic [CTL_W-1:0] ct_a[];
    n = s_de.size() + LOOK + 1;
    de_a = new[n];
    px_a = new[n];
    ct_a = new[n];
    for (int k = 0; k < n; k++) begin
      if (k <= LOOK) begin
        de_a[k] = 1'b0; px_a[k] = '0; ct_a[k] = '0;
      end else begin
        de_a[k] = s_de[k-LOOK-1]; px_a[k] = s_pix[k-LOOK-1]; ct_a[k] = s_ctl[k-LOOK-1];
      end
    end
    run = 0;
    for (int k = 0; k < n; k++) begin
      bit fut, pst;
      logic [WORD_W-1:0] w;
      string tg;
      int lo, d;
      fut = 1'b0; pst = 1'b0;
      for (int j = 1; j <= LOOK; j++) begin
        if (k + j < n && de_a[k+j]) fut = 1'b1;
        if (k - j >= 0 && de_a[k-j]) pst = 1'b1;
      end
      if (!de_a[k] && (fut || pst)) begin
        w = 20'h003FF;
        if (fut && pst)  tg = "R5/R6/R7/R11 guard in short gap";
        else if (fut)    tg = "R5/R6 guard before video";
        else             tg = "R5/R7 guard after video";
      end else begin
        w = '0;
        if (de_a[k]) begin
          lo = 2;
          for (int b = 0; b < PIX_W; b++) w[b+2] = px_a[k][b];
          tg = "R2/R3/R8/R9/R10 video word";
        end else begin
          lo = 1;
          for (int b = 1; b <= 15; b++) w[b] = ct_a[k][(b-1)/3];
          for (int b = 16; b < WORD_W; b++) w[b] = ct_a[k][b-11];
          tg = "R2/R4/R8/R9/R10 control word";
        end
        d = 2 * weight(w, lo) - (WORD_W - lo);
        if ((run > 0 && d > 0) || (run < 0 && d < 0)) begin
          for (int b = lo; b < WORD_W; b++) w[b] = ~w[b];
          w[0] = 1'b1;
        end
        if (de_a[k]) w[1] = 1'b1;
      end
      run += 2 * weight(w, 0) - WORD_W;
      exp_q.push_back(w);
      tag_q.push_back(tg);
    end
  endtask

  // combined driver/monitor at the falling edge
  int                ph = 0;
  int                si = 0;
  int                bit_idx = 0;
  int                rx_rd = 0;
  int                idle_checks = 0;
  bit                active = 1'b0;
  bit                seen = 1'b0;
  bit                done = 1'b0;
  logic [WORD_W-1:0] acc = '0;

  always @(negedge clk_ser) begin
    if (!rst_n) begin
      check("R1 reset serial output", 32'(ser_out), 32'd0);
    end else begin
      if (word_en) begin
        bit_idx = 0;
        active  = 1'b1;
        seen    = 1'b1;
      end
      if (active) begin
        acc[bit_idx] = ser_out;
        if (bit_idx == WORD_W - 1) begin
          active = 1'b0;
          if (exp_q.size() > 0) begin
            logic [WORD_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(acc), 32'(e));
            rx_rd += 2 * weight(acc, 0) - WORD_W;
            check("R9 running disparity bound", 32'(rx_rd > WORD_W || rx_rd < -WORD_W), 32'd0);
            if (exp_q.size() == 0) done = 1'b1;
          end
        end else begin
          bit_idx++;
        end
      end else if (!seen && idle_checks < 4) begin
        idle_checks++;
        check("R1 idle before first strobe", 32'(ser_out), 32'd0);
      end
      ph = (ph == WORD_W - 1) ? 0 : ph + 1;
      word_en = (ph == WORD_W - 1);
      if (word_en) begin
        if (si < s_de.size()) begin
          pix_valid = s_de[si];
          pix_data  = s_pix[si];
          ctl_data  = s_ctl[si];
          si++;
        end else begin
          pix_valid = 1'b0;
          pix_data  = '0;
          ctl_data  = '0;
        end
      end
    end
  end

  initial begin
    // blanking with varied control, including extreme weights
    add_slot(1'b0, 18'h3FFFF, 9'h1FF);
    add_slot(1'b0, 18'h00000, 9'h1FF);
    add_slot(1'b0, 18'h12345, 9'h000);
    add_ctrl(4, 3);
    // video burst with disparity-heavy pixels
    add_slot(1'b1, 18'h3FFFF, 9'h1FF);
    add_slot(1'b1, 18'h3FFFF, 9'h000);
    add_slot(1'b1, 18'h00000, 9'h155);
    add_slot(1'b1, 18'h00000, 9'h0AA);
    add_slot(1'b1, 18'h2AAAA, 9'h1FF);
    add_slot(1'b1, 18'h3F000, 9'h001);
    add_video(6, 11);
    add_ctrl(6, 7);
    add_video(1, 40);      // single-slot burst
    add_ctrl(3, 21);       // short gap
    add_video(3, 50);
    add_ctrl(1, 33);       // one-slot gap
    add_video(2, 60);
    add_ctrl(5, 44);       // gap with one control slot
    add_video(4, 70);
    add_slot(1'b0, 18'h3FFFF, 9'h000);
    add_slot(1'b0, 18'h3FFFF, 9'h1FF);
    add_slot(1'b0, 18'h00000, 9'h1FF);
    add_slot(1'b0, 18'h00000, 9'h1F0);
    add_ctrl(8, 90);
    build_expected();
    repeat (5) @(negedge clk_ser);
    rst_n = 1'b1;
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_ser);
        n_vec++;
        n_bad++;
        $display("FAIL R2 watchdog: got %0d words pending expected 0", exp_q.size());
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule